// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block collects uncached 8-byte stores from a single core into a small pool of line entries. Each entry covers one naturally aligned 64-byte line. Stores that land in a line that is already open are merged into that line's entry, so the downstream device sees fewer and wider writes. The core may interleave stores across several lines at once, and each of those lines holds its own entry.

An entry whose 64 bytes have all been written leaves as one full-line write with every mask bit set. A flush request drains every open entry. A line that is only partly written leaves as one masked write for each contiguous run of written bytes. When a store opens a new line and no entry is free, the oldest entry is drained first and the store waits until its entry is released. The downstream side is a valid/ready write port. It carries a line address, 64 bytes of data and a 64-bit byte mask.

Top module: `wc_store_buffer`

## Requirements
- R1: After reset no entry is open: `st_ready` is high, `wr_valid` is low and `flush_done` is low.
- R2: A store word address `st_waddr` splits into a line tag (`st_waddr[ADDR_W-4:3]`) and a lane (`st_waddr[2:0]`). Bit `st_be[i]` writes line byte `8*lane+i` from `st_data[8i+7:8i]`. All stores to one line merge into a single entry, a later store to a byte replaces the earlier value, and no two entries ever hold the same tag.
- R3: Up to `NUM_ENTRIES` distinct lines can be open at the same time, with stores interleaved among them, and none of this causes a downstream write. An entry that is not open holds no valid bytes.
- R4: An entry whose 64 bytes are all valid drains as exactly one write. That write has `wr_mask` all ones and `wr_addr` equal to the line base (tag shifted left by 6, low six bits zero). `wr_data[8k+7:8k]` carries line byte k. The write is presented starting one clock after the line becomes complete, and full entries have priority over every other drain.
- R5: A partly written entry drains as one write for each maximal contiguous run of valid bytes, in ascending byte order. Each of these writes has only that run's bits set in `wr_mask`.
- R6: A `flush_req` pulse starts a flush. While the flush runs, stores are stalled and open entries drain oldest first. `flush_done` pulses for one cycle once every entry has been accepted downstream and the pool is empty. A `flush_req` that arrives during a flush has no effect.
- R7: A store to a new line when no entry is free is stalled (`st_ready` low). The oldest allocated entry is drained, partial runs included, and the store is then accepted into the released entry.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_mask` and `wr_data` hold their values.
- R9: A store to the line that is currently draining is stalled until that drain ends. Stores that hit other open lines, or that allocate a free entry, are still accepted during the drain.
- R10: Every byte accepted downstream equals the most recent stored value for that byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high together with st_valid |
| st_waddr | input | ADDR_W-3 | Store address in 8-byte words |
| st_data | input | 64 | Store data, byte i in bits 8i+7:8i |
| st_be | input | 8 | Byte enables of the store |
| flush_req | input | 1 | Request to drain all open entries |
| flush_done | output | 1 | One-cycle pulse when a flush has finished |
| wr_valid | output | 1 | Downstream write present |
| wr_ready | input | 1 | Downstream accepts the write |
| wr_addr | output | ADDR_W | Line base address of the write |
| wr_data | output | 512 | Line data; only masked bytes are meaningful |
| wr_mask | output | 64 | Byte mask of the write |

## Verification
Several properties are checked on every cycle by the assertions. Tags stay unique across entries, a closed entry holds no bytes, and exactly one entry is oldest while any entry is open. Every presented mask is a single non-empty contiguous run, a stalled write keeps its payload, and a released entry never takes a merge in the same cycle. Other behaviour can only be shown by the bench's scenarios against its reference model. These are: full lines leaving as one burst, runs of a partial line leaving in ascending order, the flush order and its done pulse, the choice of eviction victim, stalls on the draining line, and whether the bytes that reach the device match the most recent stores.

// File: rtl/wcb_pkg.sv
// Package wcb_pkg
// Line geometry shared by the write-combining buffer modules.
// Assumes 64-byte lines built from eight 8-byte store lanes.
package wcb_pkg;
    localparam int LINE_BYTES = 64;
    localparam int LANE_BYTES = 8;
    localparam int LANES      = LINE_BYTES / LANE_BYTES;
    localparam int LANE_W     = $clog2(LANES);
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int STORE_W    = LANE_BYTES * 8;
endpackage

// File: rtl/wcb_line_slot.sv
// Module wcb_line_slot
// Holds one combining entry: valid flag, line tag, byte-valid mask,
// line data and age rank. Merges one 8-byte store lane per cycle.
// Assumes: release and write never target the slot in the same cycle;
// alloc only arrives while the slot is empty.
module wcb_line_slot import wcb_pkg::*; #(
    parameter int TAG_W  = 26,
    parameter int RANK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_i,
    input  logic                  write_i,
    input  logic                  release_i,
    input  logic                  dec_rank_i,
    input  logic [TAG_W-1:0]      tag_i,
    input  logic [LANE_W-1:0]     lane_i,
    input  logic [LANE_BYTES-1:0] be_i,
    input  logic [STORE_W-1:0]    data_i,
    input  logic [RANK_W-1:0]     rank_i,
    output logic                  valid_o,
    output logic [TAG_W-1:0]      tag_o,
    output logic [LINE_BYTES-1:0] mask_o,
    output logic [LINE_W-1:0]     data_o,
    output logic [RANK_W-1:0]     rank_o
);
    logic [LINE_BYTES-1:0] lane_bits;

    // Place the store's byte enables at its lane inside the line mask.
    always_comb begin
        lane_bits = LINE_BYTES'(be_i) << {lane_i, 3'b000};
    end

    // Control state: occupancy, tag, byte-valid mask and age rank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            tag_o   <= '0;
            mask_o  <= '0;
            rank_o  <= '0;
        end else begin
            if (release_i) begin
                valid_o <= 1'b0;
                mask_o  <= '0;
            end else if (alloc_i) begin
                valid_o <= 1'b1;
                tag_o   <= tag_i;
                mask_o  <= lane_bits;
            end else if (write_i) begin
                mask_o  <= mask_o | lane_bits;
            end
            if (alloc_i)
                rank_o <= rank_i;
            else if (dec_rank_i)
                rank_o <= rank_o - 1'b1;
        end
    end

    // Data bytes: the newest store to a byte overwrites it.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            for (int b = 0; b < LANE_BYTES; b++) begin
                if (write_i && lane_i == LANE_W'(l) && be_i[b])
                    data_o[(l*LANE_BYTES+b)*8 +: 8] <= data_i[b*8 +: 8];
            end
        end
    end

    assert_empty_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> mask_o == '0)
        else $error("closed slot holds bytes");

    assert_no_merge_on_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> !write_i)
        else $error("store merged into a slot being released");
endmodule

// File: rtl/wcb_run_finder.sv
// Module wcb_run_finder
// Returns the lowest contiguous run of set bits in a mask.
// Pure combinational; uses a carry through the run to find its end.
// Assumes nothing about the input; an all-zero input gives zero.
module wcb_run_finder #(
    parameter int W = 64
) (
    input  logic [W-1:0] bits_in,
    output logic [W-1:0] run_out
);
    logic [W-1:0] lowest;
    logic [W-1:0] carried;

    // Isolate the lowest set bit, ripple it through the run, keep the run.
    always_comb begin
        lowest  = bits_in & (~bits_in + W'(1));
        carried = bits_in + lowest;
        run_out = bits_in & ~carried;
    end
endmodule

// File: rtl/wc_store_buffer.sv
// Module wc_store_buffer
// Write-combining store buffer for one core. Merges 8-byte stores into
// 64-byte line entries, drains full lines as single bursts, drains partial
// lines (on flush or eviction) as one write per contiguous byte run.
// Assumes: one drain engine; stores stall during a flush, on a hit to the
// draining line, and on a miss with no free entry.
module wc_store_buffer import wcb_pkg::*; #(
    parameter int ADDR_W      = 32,
    parameter int NUM_ENTRIES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [ADDR_W-4:0]     st_waddr,
    input  logic [STORE_W-1:0]    st_data,
    input  logic [LANE_BYTES-1:0] st_be,
    input  logic                  flush_req,
    output logic                  flush_done,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [LINE_W-1:0]     wr_data,
    output logic [LINE_BYTES-1:0] wr_mask
);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam int CNT_W = IDX_W + 1;

    logic [NUM_ENTRIES-1:0] valid_v, hit_v, full_v, old_v;
    logic [NUM_ENTRIES-1:0] alloc_v, write_v, rel_v, dec_v;
    logic [TAG_W-1:0]       tag_a  [NUM_ENTRIES];
    logic [LINE_BYTES-1:0]  mask_a [NUM_ENTRIES];
    logic [LINE_W-1:0]      data_a [NUM_ENTRIES];
    logic [IDX_W-1:0]       rank_a [NUM_ENTRIES];

    logic [TAG_W-1:0]      tag_in;
    logic [LANE_W-1:0]     lane_in;
    logic                  busy_q, flush_q;
    logic [IDX_W-1:0]      cur_q;
    logic [LINE_BYTES-1:0] rem_q, run;
    logic [IDX_W-1:0]      hit_idx, free_idx, full_idx, old_idx, start_idx, new_rank;
    logic                  hit_any, free_any, full_any, any_valid;
    logic                  accept, last_beat, st_fire, alloc_go, start_go;
    logic [CNT_W-1:0]      valid_cnt;

    assign tag_in  = st_waddr[ADDR_W-4:LANE_W];
    assign lane_in = st_waddr[LANE_W-1:0];

    // Per-entry storage and per-entry control decode.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        assign hit_v[g]   = valid_v[g] && tag_a[g] == tag_in;
        assign full_v[g]  = valid_v[g] && (&mask_a[g]);
        assign old_v[g]   = valid_v[g] && rank_a[g] == '0;
        assign alloc_v[g] = alloc_go && free_idx == IDX_W'(g);
        assign write_v[g] = st_fire && (hit_any ? hit_idx == IDX_W'(g)
                                                : free_idx == IDX_W'(g));
        assign rel_v[g]   = last_beat && cur_q == IDX_W'(g);
        assign dec_v[g]   = last_beat && valid_v[g] && rank_a[g] > rank_a[cur_q];

        wcb_line_slot #(.TAG_W(TAG_W), .RANK_W(IDX_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(alloc_v[g]), .write_i(write_v[g]),
            .release_i(rel_v[g]), .dec_rank_i(dec_v[g]),
            .tag_i(tag_in), .lane_i(lane_in), .be_i(st_be), .data_i(st_data),
            .rank_i(new_rank),
            .valid_o(valid_v[g]), .tag_o(tag_a[g]), .mask_o(mask_a[g]),
            .data_o(data_a[g]), .rank_o(rank_a[g])
        );
    end

    // Lowest-index encoders for hit, free, full and oldest entries.
    always_comb begin
        hit_idx = '0; free_idx = '0; full_idx = '0; old_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_v[i])    hit_idx  = IDX_W'(i);
            if (!valid_v[i]) free_idx = IDX_W'(i);
            if (full_v[i])   full_idx = IDX_W'(i);
            if (old_v[i])    old_idx  = IDX_W'(i);
        end
    end

    assign hit_any   = |hit_v;
    assign free_any  = ~&valid_v;
    assign full_any  = |full_v;
    assign any_valid = |valid_v;
    assign valid_cnt = CNT_W'($countones(valid_v));

    // Next byte run of the draining entry.
    wcb_run_finder #(.W(LINE_BYTES)) u_run (.bits_in(rem_q), .run_out(run));

    assign accept    = busy_q && wr_ready;
    assign last_beat = accept && (rem_q & ~run) == '0;
    assign st_ready  = !flush_q && (hit_any ? !(busy_q && hit_idx == cur_q) : free_any);
    assign st_fire   = st_valid && st_ready;
    assign alloc_go  = st_fire && !hit_any;
    assign new_rank  = IDX_W'(valid_cnt - CNT_W'(last_beat));

    // Drain source choice: full lines, then flush victims, then eviction.
    always_comb begin
        start_go  = 1'b0;
        start_idx = full_idx;
        if (!busy_q) begin
            if (full_any) begin
                start_go = 1'b1;
            end else if (flush_q && any_valid) begin
                start_go  = 1'b1;
                start_idx = old_idx;
            end else if (!flush_q && st_valid && !hit_any && !free_any) begin
                start_go  = 1'b1;
                start_idx = old_idx;
            end
        end
    end

    // Drain engine state and flush tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cur_q   <= '0;
            rem_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            if (last_beat)
                busy_q <= 1'b0;
            else if (accept)
                rem_q <= rem_q & ~run;
            if (start_go) begin
                busy_q <= 1'b1;
                cur_q  <= start_idx;
                rem_q  <= mask_a[start_idx];
            end
            flush_q <= flush_q ? !flush_done : flush_req;
        end
    end

    assign flush_done = flush_q && !busy_q && !any_valid;
    assign wr_valid   = busy_q;
    assign wr_mask    = run;
    assign wr_addr    = {tag_a[cur_q], {OFS_W{1'b0}}};
    assign wr_data    = data_a[cur_q];

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_mask) && $stable(wr_addr) && $stable(wr_data))
        else $error("write payload changed while stalled");

    assert_run_contig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_mask != '0 && (((wr_mask | (wr_mask - 1'b1)) + 1'b1) & wr_mask) == '0)
        else $error("mask is not one contiguous run");

    assert_one_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_valid |-> $countones(old_v) == 1)
        else $error("oldest entry not unique");

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done)
        else $error("flush_done longer than one cycle");

    for (genvar a = 0; a < NUM_ENTRIES; a++) begin : g_pa
        for (genvar b = a + 1; b < NUM_ENTRIES; b++) begin : g_pb
            assert_no_dup_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !(valid_v[a] && valid_v[b] && tag_a[a] == tag_a[b]))
                else $error("two entries hold the same line");
        end
    end
endmodule

// File: tb/sim_wc_store_buffer.sv
`timescale 1ns/1ps
module sim_wc_store_buffer;
    localparam int AW = 32;
    localparam int NE = 4;

    logic clk = 1'b0;
    logic rst_n, st_valid, flush_req, wr_ready;
    logic [AW-4:0] st_waddr;
    logic [63:0] st_data;
    logic [7:0] st_be;
    logic st_ready, flush_done, wr_valid;
    logic [AW-1:0] wr_addr;
    logic [511:0] wr_data;
    logic [63:0] wr_mask;

    always #4 clk = ~clk;

    wc_store_buffer #(.ADDR_W(AW), .NUM_ENTRIES(NE)) u0 (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_waddr(st_waddr), .st_data(st_data), .st_be(st_be),
        .flush_req(flush_req), .flush_done(flush_done),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask)
    );

    int nchk = 0, nfail = 0, done_cnt = 0, rmode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    bit mv[NE];
    logic [AW-7:0] mtag[NE];
    logic [63:0] mmask[NE];
    logic [7:0] mdat[NE][64];
    int ageq[$];
    bit mbusy, mflush;
    int mcur;
    logic [63:0] mrem;
    logic [7:0] refmem[int unsigned];
    logic [7:0] devmem[int unsigned];
    logic [AW-1:0] acc_addr[$];
    logic [63:0] acc_mask[$];

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    // downstream ready pattern
    always @(posedge clk) begin
        #1;
        case (rmode)
            0: wr_ready = 1'b1;
            1: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                wr_ready = lfsr[0] | lfsr[3];
            end
            default: wr_ready = 1'b0;
        endcase
    end

    // cycle-by-cycle reference model and comparison
    int hit, fre, sel, nval, lo, hi, bad, slot, ln;
    bit e_ready, e_done, acc;
    logic [63:0] erun;
    logic [AW-7:0] tin;
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) begin mv[i] = 0; mmask[i] = '0; end
            ageq.delete();
            mbusy = 0; mflush = 0; mrem = '0; mcur = 0;
        end else begin
            tin = st_waddr[AW-4:3];
            hit = -1; fre = -1; nval = 0; sel = -1;
            for (int i = 0; i < NE; i++) begin
                if (mv[i]) nval++;
                if (mv[i] && mtag[i] == tin && hit < 0) hit = i;
                if (!mv[i] && fre < 0) fre = i;
            end
            e_ready = !mflush && (hit >= 0 ? !(mbusy && hit == mcur) : fre >= 0);
            e_done  = mflush && !mbusy && nval == 0;
            erun = '0;
            if (mbusy) begin
                lo = 0;
                while (!mrem[lo]) lo++;
                hi = lo;
                while (hi < 64 && mrem[hi]) begin erun[hi] = 1'b1; hi++; end
            end
            chk(st_ready === e_ready, "R6 R7 R9 st_ready", 64'(st_ready), 64'(e_ready));
            chk(wr_valid === mbusy, "R3 R7 wr_valid", 64'(wr_valid), 64'(mbusy));
            chk(flush_done === e_done, "R6 flush_done", 64'(flush_done), 64'(e_done));
            if (mbusy) begin
                chk(wr_mask === erun, "R4 R5 wr_mask", wr_mask, erun);
                chk(wr_addr === {mtag[mcur], 6'b0}, "R4 wr_addr", 64'(wr_addr), 64'({mtag[mcur], 6'b0}));
                bad = 0;
                for (int b = 0; b < 64; b++)
                    if (erun[b] && wr_data[b*8 +: 8] !== mdat[mcur][b]) bad++;
                chk(bad == 0, "R2 R10 wr_data bytes wrong", 64'(bad), 64'd0);
            end
            if (flush_done) done_cnt++;
            // drain selection from pre-edge state
            if (!mbusy) begin
                for (int i = 0; i < NE; i++)
                    if (sel < 0 && mv[i] && mmask[i] == '1) sel = i;
                if (sel < 0 && ageq.size() > 0 &&
                    (mflush || (st_valid && hit < 0 && fre < 0)))
                    sel = ageq[0];
            end
            acc = mbusy && wr_ready;
            if (acc) begin
                for (int b = 0; b < 64; b++)
                    if (wr_mask[b]) devmem[wr_addr + b] = wr_data[b*8 +: 8];
                acc_addr.push_back(wr_addr);
                acc_mask.push_back(wr_mask);
                mrem = mrem & ~erun;
                if (mrem == '0) begin
                    mv[mcur] = 0; mmask[mcur] = '0; mbusy = 0;
                    for (int k = 0; k < ageq.size(); k++)
                        if (ageq[k] == mcur) begin ageq.delete(k); break; end
                end
            end
            if (sel >= 0) begin mbusy = 1; mcur = sel; mrem = mmask[sel]; end
            if (st_valid && e_ready) begin
                slot = (hit >= 0) ? hit : fre;
                if (hit < 0) begin
                    mv[slot] = 1; mtag[slot] = tin; mmask[slot] = '0;
                    ageq.push_back(slot);
                end
                ln = int'(st_waddr[2:0]);
                for (int b = 0; b < 8; b++) if (st_be[b]) begin
                    mmask[slot][ln*8+b] = 1'b1;
                    mdat[slot][ln*8+b] = st_data[b*8 +: 8];
                    refmem[{st_waddr, 3'b000} + b] = st_data[b*8 +: 8];
                end
            end
            if (mflush) begin
                if (e_done) mflush = 0;
            end else if (flush_req) mflush = 1;
        end
    end

    function automatic logic [AW-4:0] wa(input int line, input int lane);
        return (AW-3)'(line * 8 + lane);
    endfunction

    task automatic wait_accept();
        forever begin
            @(negedge clk);
            if (st_ready) begin @(posedge clk); #1; break; end
        end
        st_valid = 1'b0;
    endtask

    task automatic put(input int line, input int lane, input logic [63:0] d, input logic [7:0] be);
        st_valid = 1'b1; st_waddr = wa(line, lane); st_data = d; st_be = be;
        wait_accept();
    endtask

    task automatic do_flush();
        int d0;
        d0 = done_cnt;
        flush_req = 1'b1;
        @(posedge clk); #1;
        flush_req = 1'b0;
        while (done_cnt == d0) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; st_valid = 0; flush_req = 0; wr_ready = 0;
        st_waddr = '0; st_data = '0; st_be = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(st_ready === 1'b1, "R1 st_ready after reset", 64'(st_ready), 64'd1);
        chk(wr_valid === 1'b0, "R1 wr_valid after reset", 64'(wr_valid), 64'd0);
        chk(flush_done === 1'b0, "R1 flush_done after reset", 64'(flush_done), 64'd0);
        @(posedge clk); #1;

        // R3/R4: interleaved lines, one of them completed
        acc_addr.delete(); acc_mask.delete();
        put(1, 0, 64'h1111_2222_3333_4444, 8'h0F);
        put(16, 0, 64'hA0A0_A0A0_A0A0_A0A0, 8'hFF);
        put(2, 4, 64'h5555_6666_7777_8888, 8'hF0);
        for (int l = 1; l < 8; l++) put(16, l, {8{8'(l)}}, 8'hFF);
        repeat (6) @(posedge clk); #1;
        chk(acc_addr.size() == 1, "R3 R4 write count", 64'(acc_addr.size()), 64'd1);
        chk(acc_mask[0] == '1, "R4 full mask", acc_mask[0], '1);
        chk(acc_addr[0] == 32'(16 << 6), "R4 line base", 64'(acc_addr[0]), 64'(16 << 6));

        // R2/R5/R6: merge, later store wins, partial runs in order on flush
        acc_addr.delete(); acc_mask.delete();
        put(3, 2, 64'h0102_0304_0506_0708, 8'h0F);
        put(3, 2, 64'hC1C2_C3C4_C5C6_C7C8, 8'hFF);
        put(3, 5, 64'hEE00_0000_0000_00DD, 8'h81);
        do_flush();
        chk(done_cnt == 1, "R6 one done pulse", 64'(done_cnt), 64'd1);
        chk(acc_addr.size() == 5, "R5 R6 write count", 64'(acc_addr.size()), 64'd5);
        if (acc_addr.size() == 5) begin
            chk(acc_addr[0] == 32'(1 << 6) && acc_mask[0] == 64'h0F, "R6 oldest first", acc_mask[0], 64'h0F);
            chk(acc_mask[1] == 64'h0000_00F0_0000_0000, "R5 second line run", acc_mask[1], 64'h0000_00F0_0000_0000);
            chk(acc_mask[2] == 64'h0000_0000_00FF_0000, "R5 first run", acc_mask[2], 64'h0000_0000_00FF_0000);
            chk(acc_mask[3] == 64'h0000_0100_0000_0000, "R5 second run", acc_mask[3], 64'h0000_0100_0000_0000);
            chk(acc_mask[4] == 64'h0000_8000_0000_0000, "R5 third run", acc_mask[4], 64'h0000_8000_0000_0000);
        end
        chk(devmem[(3 << 6) + 16] == 8'hC8, "R2 later store wins", 64'(devmem[(3 << 6) + 16]), 64'hC8);
        chk(devmem[(3 << 6) + 20] == 8'hC4, "R2 merged byte", 64'(devmem[(3 << 6) + 20]), 64'hC4);

        // R7/R8: eviction of the oldest entry with downstream stalled
        acc_addr.delete(); acc_mask.delete();
        rmode = 2;
        for (int n = 4; n < 8; n++) put(n, 0, 64'(n), 8'h01);
        st_valid = 1; st_waddr = wa(8, 0); st_data = 64'h88; st_be = 8'h01;
        repeat (6) @(negedge clk);
        chk(st_ready === 1'b0, "R7 store stalled", 64'(st_ready), 64'd0);
        chk(wr_valid === 1'b1 && wr_addr == 32'(4 << 6), "R7 victim is oldest", 64'(wr_addr), 64'(4 << 6));
        chk(wr_mask == 64'h1, "R8 held mask", wr_mask, 64'h1);
        @(posedge clk); #1;
        rmode = 0;
        wait_accept();
        chk(acc_addr.size() >= 1 && acc_addr[0] == 32'(4 << 6), "R7 evicted line", 64'(acc_addr[0]), 64'(4 << 6));
        do_flush();

        // R9: store to the draining line stalls, other lines proceed
        acc_addr.delete(); acc_mask.delete();
        rmode = 2;
        for (int l = 0; l < 8; l++) put(9, l, {8{8'(l + 9)}}, 8'hFF);
        put(10, 3, 64'h1010, 8'h03);
        st_valid = 1; st_waddr = wa(9, 1); st_data = 64'h99; st_be = 8'h01;
        repeat (3) @(negedge clk);
        chk(st_ready === 1'b0, "R9 hit on draining line stalled", 64'(st_ready), 64'd0);
        @(posedge clk); #1;
        rmode = 0;
        wait_accept();
        do_flush();
        chk(acc_mask[0] == '1 && acc_addr[0] == 32'(9 << 6), "R9 R4 full drain first", acc_mask[0], '1);

        // R10: random traffic with random downstream stalls and flushes
        rmode = 1;
        for (int it = 0; it < 500; it++) begin
            put(20 + int'($urandom_range(0, 5)), int'($urandom_range(0, 7)),
                {$urandom, $urandom}, 8'($urandom));
            if (it % 60 == 59) do_flush();
        end
        do_flush();
        bad = 0;
        foreach (refmem[a]) if (!devmem.exists(a) || devmem[a] !== refmem[a]) bad++;
        chk(bad == 0, "R10 device bytes match stores", 64'(bad), 64'd0);
        finish_run();
    end
endmodule